// File: doc/BRIEF.md
# 100BASE-X Transmit Symbol Encoder

This block turns the 4-bit transmit nibbles that a MAC presents into the serial symbol stream that drives a fast-Ethernet line. It runs on one bit-rate clock, with five bit periods per nibble. A nibble strobe tells the MAC when its nibble is taken, so the strobe plays the part of the nibble transmit clock. Each accepted nibble becomes a 5-bit code group. Frame boundaries are marked by delimiter groups in place of the first two preamble nibbles and after the last data nibble. In copper mode the groups are scrambled with an 11-bit keystream, shifted out most significant bit first, converted to NRZI and then to a three-level MLT-3 line level.

In fiber mode there is no code-group mapping and no scrambling. The MAC supplies the raw 5-bit symbol itself, using the error input as the top bit. The serial stream leaves on the NRZI output and the three-level output rests at zero.

Top module: `tx_symbol_chain`

## Requirements
- R1: `nib_tick` is high for exactly one clock in every five. The inputs are sampled on the rising edge at which `nib_tick` is high.
- R2: In copper mode a data nibble maps to this 5-bit group: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R3: When idle, the first nibble sampled with `tx_en` high is sent as 11000 and the next nibble as 10001, whatever its data, `tx_er` or `tx_en` value.
- R4: After the 10001 group, the first nibble sampled with `tx_en` low is sent as 01101, the next as 00111, and 11111 follows while `tx_en` stays low.
- R5: A data nibble sampled with both `tx_en` and `tx_er` high is sent as 00100.
- R6: `tx_er` while `tx_en` is low has no effect: the line keeps carrying 11111.
- R7: In copper mode every serial bit is XORed with a key bit `k = s[10] ^ s[8]`. `k` is then shifted into bit 0 of the 11-bit state `s`, which moves every clock and resets to the nonzero `SCR_SEED`.
- R8: Each group is sent in five consecutive clocks, bit 4 first.
- R9: `line_nrzi` toggles on every clock whose serial bit is 1 and holds otherwise.
- R10: `line_lvl` is coded 00 = 0, 01 = +1, 11 = −1. It advances one step along 0, +1, 0, −1 on each 1 bit and holds on each 0 bit. It starts at 0 with the next nonzero level +1.
- R11: In fiber mode the sent symbol is `{tx_er, txd}` without delimiters or scrambling, and `line_lvl` stays 00.
- R12: While `rst_n` is low, `line_lvl` is 00 and `line_nrzi` and `nib_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fiber_mode | input | 1 | 1 selects raw 5-bit symbol mode with no scrambling; held steady between resets |
| tx_en | input | 1 | Frame enable from the MAC |
| tx_er | input | 1 | Error flag from the MAC; fifth symbol bit in fiber mode |
| txd | input | 4 | Transmit nibble |
| nib_tick | output | 1 | High on the clock whose edge samples the inputs |
| line_nrzi | output | 1 | NRZI serial line bit |
| line_lvl | output | 2 | Signed MLT-3 level |

## Verification
The hardest thing to observe from the ports is the recovered data. The only outputs are a scrambled, NRZI-coded, three-level waveform, so the nibbles can be checked only by undoing every stage. The bench does this with its own receiver model. It infers the keystream from the known all-ones idle after reset, locks onto the 11000/10001 pair to find group boundaries, and then unscrambles and decodes each group. The vectors steer `tx_er` into the delimiter slot, into a data slot and outside a frame. They also send a one-nibble frame, so the tail groups follow the start groups with no data between them.

// File: rtl/tx_symbol_chain.sv
module tx_symbol_chain #(
  parameter int SCR_LEN = 11,
  parameter int SCR_TAP = 9,
  parameter logic [SCR_LEN-1:0] SCR_SEED = 11'h2B7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fiber_mode,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  output logic       nib_tick,
  output logic       line_nrzi,
  output logic [1:0] line_lvl
);
  localparam int SYM_W = 5;
  localparam int PH_W  = $clog2(SYM_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYM_W - 1);
  localparam logic [SYM_W-1:0] G_IDLE = 5'b11111, G_J = 5'b11000, G_K = 5'b10001,
                               G_T = 5'b01101, G_R = 5'b00111, G_H = 5'b00100;

  typedef enum logic [1:0] {F_IDLE, F_K, F_DATA, F_R} fstate_t;

  function automatic logic [SYM_W-1:0] map4b5b(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110;  4'h1: return 5'b01001;
      4'h2: return 5'b10100;  4'h3: return 5'b10101;
      4'h4: return 5'b01010;  4'h5: return 5'b01011;
      4'h6: return 5'b01110;  4'h7: return 5'b01111;
      4'h8: return 5'b10010;  4'h9: return 5'b10011;
      4'hA: return 5'b10110;  4'hB: return 5'b10111;
      4'hC: return 5'b11010;  4'hD: return 5'b11011;
      4'hE: return 5'b11100;  default: return 5'b11101;
    endcase
  endfunction

  logic [PH_W-1:0]    ph;
  fstate_t            st, st_nx;
  logic [SYM_W-1:0]   shreg, grp_nx;
  logic [SCR_LEN-1:0] lfsr;
  logic               key, tx_bit, nrzi_q;
  logic [1:0]         step_q;

  assign nib_tick = (ph == PH_LAST);

  always_comb begin
    st_nx  = st;
    grp_nx = G_IDLE;
    if (fiber_mode) begin
      grp_nx = {tx_er, txd};
      st_nx  = F_IDLE;
    end else begin
      case (st)
        F_IDLE: if (tx_en) begin grp_nx = G_J; st_nx = F_K; end
        F_K:    begin grp_nx = G_K; st_nx = F_DATA; end
        F_DATA: if (!tx_en)     begin grp_nx = G_T; st_nx = F_R; end
                else if (tx_er) grp_nx = G_H;
                else            grp_nx = map4b5b(txd);
        default: begin grp_nx = G_R; st_nx = F_IDLE; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= '0;
      st    <= F_IDLE;
      shreg <= G_IDLE;
    end else if (nib_tick) begin
      ph    <= '0;
      st    <= st_nx;
      shreg <= grp_nx;
    end else begin
      ph    <= ph + 1'b1;
      shreg <= {shreg[SYM_W-2:0], 1'b1};
    end
  end

  assign key    = lfsr[SCR_LEN-1] ^ lfsr[SCR_TAP-1];
  assign tx_bit = shreg[SYM_W-1] ^ (key & ~fiber_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr   <= SCR_SEED;
      nrzi_q <= 1'b0;
      step_q <= 2'd0;
    end else begin
      lfsr   <= {lfsr[SCR_LEN-2:0], key};
      nrzi_q <= nrzi_q ^ tx_bit;
      if (!fiber_mode && tx_bit) step_q <= step_q + 2'd1;
    end
  end

  assign line_nrzi = nrzi_q;
  assign line_lvl  = fiber_mode ? 2'b00 : {step_q == 2'd3, step_q[0]};

  a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    nib_tick |=> !nib_tick);
  a_r3_start_j: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_tick && !fiber_mode && st == F_IDLE && tx_en) |=> shreg == G_J);
  a_r5_halt_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_tick && !fiber_mode && st == F_DATA && tx_en && tx_er) |=> shreg == G_H);
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_tick && !fiber_mode && st == F_IDLE && !tx_en) |=> shreg == G_IDLE);
  a_r10_lvl_code: assert property (@(posedge clk) disable iff (!rst_n)
    line_lvl != 2'b10);
  a_r10_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_lvl) |-> ($past(line_lvl) == 2'b00 || line_lvl == 2'b00));
  a_r9_nrzi_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (!fiber_mode && $past(!fiber_mode) && !$stable(line_nrzi)) |-> !$stable(line_lvl));
endmodule

// File: tb/tx_symbol_chain_tb_top.sv
module tx_symbol_chain_tb_top;
  localparam time HALF = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, fiber_mode = 1'b0;
  logic tx_en = 1'b0, tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic nib_tick, line_nrzi;
  logic [1:0] line_lvl;

  tx_symbol_chain dut_i (.clk(clk), .rst_n(rst_n), .fiber_mode(fiber_mode), .tx_en(tx_en),
    .tx_er(tx_er), .txd(txd), .nib_tick(nib_tick), .line_nrzi(line_nrzi), .line_lvl(line_lvl));

  always #HALF clk = ~clk;

  // Stimulus vectors: nibble pool and frames {first pool index, length with 2 preamble nibbles, error slot or -1}
  localparam logic [3:0] NIB_TAB [0:23] = '{4'h0,4'h1,4'h2,4'h3,4'h4,4'h5,4'h6,4'h7,4'h8,4'h9,
    4'hA,4'hB,4'hC,4'hD,4'hE,4'hF,4'hD,4'h5,4'h0,4'hF,4'h3,4'hC,4'h7,4'h8};
  localparam int FR_TAB [0:5][0:2] = '{'{0,18,-1}, '{16,6,-1}, '{4,7,4}, '{9,5,1}, '{0,1,-1}, '{20,4,3}};
  localparam logic [4:0] FIB_SYM [0:5] = '{5'b00000, 5'b10101, 5'b01010, 5'b11110, 5'b00011, 5'b10000};

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int dec5(input logic [4:0] g);
    case (g)
      5'b11110: return 0;  5'b01001: return 1;  5'b10100: return 2;  5'b10101: return 3;
      5'b01010: return 4;  5'b01011: return 5;  5'b01110: return 6;  5'b01111: return 7;
      5'b10010: return 8;  5'b10011: return 9;  5'b10110: return 10; 5'b10111: return 11;
      5'b11010: return 12; 5'b11011: return 13; 5'b11100: return 14; 5'b11101: return 15;
      5'b00100: return 16;
      default:  return 17;
    endcase
  endfunction

  // Receiver model: bit recovery, keystream sync on idle, J/K lock, group capture (R7 R8 R9 R10)
  logic [1:0]  prev_lvl, last_nz;
  logic        prev_nrzi;
  logic [10:0] hist;
  logic [9:0]  win;
  logic [4:0]  cur, rx_end;
  logic [4:0]  rx_sym [0:63];
  int nsync, bitc, rx_n, frames, hunt_zero, gap;
  int tick_bad, lvl_bad, nrzi_bad, fib_lvl_bad;
  bit hunting, got_t, tick_seen;

  always @(negedge clk) begin
    logic b, d, k;
    logic [1:0] e;
    if (!rst_n) begin
      prev_lvl = 2'b00; prev_nrzi = 1'b0; last_nz = 2'b11; nsync = 0;
      hunting = 1'b1; win = '1; bitc = 0; got_t = 1'b0; gap = 0; tick_seen = 1'b0;
    end else begin
      gap++;
      if (nib_tick) begin
        if (tick_seen && gap != 5) tick_bad++;
        tick_seen = 1'b1; gap = 0;
      end
      if (fiber_mode && line_lvl != 2'b00) fib_lvl_bad++;
      if (!fiber_mode && ((line_lvl != prev_lvl) != (line_nrzi != prev_nrzi))) nrzi_bad++;
      if (!fiber_mode && line_lvl != prev_lvl) begin
        e = (prev_lvl != 2'b00) ? 2'b00 : ((last_nz == 2'b01) ? 2'b11 : 2'b01);
        if (line_lvl != e) lvl_bad++;
        if (line_lvl != 2'b00) last_nz = line_lvl;
      end
      b = fiber_mode ? (line_nrzi != prev_nrzi) : (line_lvl != prev_lvl);
      prev_lvl = line_lvl; prev_nrzi = line_nrzi;
      if (!fiber_mode && nsync < 11) begin
        hist = {hist[9:0], ~b};
        nsync++;
      end else begin
        if (fiber_mode) d = b;
        else begin
          k = hist[10] ^ hist[8];
          hist = {hist[9:0], k};
          d = b ^ k;
        end
        if (hunting) begin
          win = {win[8:0], d};
          if (!d) hunt_zero++;
          if (win == 10'b1100010001) begin
            hunting = 1'b0; bitc = 0; rx_n = 0; got_t = 1'b0;
          end
        end else begin
          cur = {cur[3:0], d};
          bitc++;
          if (bitc == 5) begin
            bitc = 0;
            if (got_t) begin
              rx_end = cur; hunting = 1'b1; win = '1; frames++;
            end else if (cur == 5'b01101) got_t = 1'b1;
            else if (rx_n < 64) begin
              rx_sym[rx_n] = cur; rx_n++;
            end
          end
        end
      end
    end
  end

  task automatic put(input logic en, input logic er, input logic [3:0] d);
    do @(negedge clk); while (!nib_tick);
    tx_en = en; tx_er = er; txd = d;
  endtask

  task automatic do_reset(input logic fib);
    rst_n = 1'b0; fiber_mode = fib; tx_en = 1'b0; tx_er = fib; txd = fib ? 4'hF : 4'h0;
    repeat (6) @(negedge clk);
    chk(line_lvl == 2'b00 && line_nrzi == 1'b0 && nib_tick == 1'b0, "R12 reset outputs",
        {line_lvl, line_nrzi, nib_tick}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) put(1'b0, fib, fib ? 4'hF : 4'h0);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int f0, z0, nd, first, len, erp, ex;
    frames = 0; hunt_zero = 0; tick_bad = 0; lvl_bad = 0; nrzi_bad = 0; fib_lvl_bad = 0;
    hist = '0; cur = '0; rx_end = '0; rx_n = 0;
    do_reset(1'b0);

    // Vector walk: copper frames (R2 R3 R4 R5 R7 R8)
    for (int f = 0; f < 6; f++) begin
      first = FR_TAB[f][0]; len = FR_TAB[f][1]; erp = FR_TAB[f][2];
      f0 = frames;
      for (int i = 0; i < len; i++)
        put(1'b1, i == erp, (i < 2) ? 4'h5 : NIB_TAB[first + i - 2]);
      for (int i = 0; i < 8; i++) put(1'b0, 1'b0, 4'h0);
      chk(frames == f0 + 1, "R3 start pair detected", frames - f0, 1);
      nd = (len > 2) ? len - 2 : 0;
      chk(rx_n == nd, "R4 data group count before 01101", rx_n, nd);
      chk(rx_end == 5'b00111, "R4 closing group", rx_end, 7);
      for (int i = 0; i < nd && i < rx_n; i++) begin
        ex = (i + 2 == erp) ? 16 : NIB_TAB[first + i];
        chk(dec5(rx_sym[i]) == ex, (ex == 16) ? "R5 halt group" : "R2 R7 R8 nibble recovered",
            dec5(rx_sym[i]), ex);
      end
    end

    // R6: error flag outside a frame leaves the line idle
    f0 = frames; z0 = hunt_zero;
    for (int i = 0; i < 6; i++) put(1'b0, 1'b1, 4'h3);
    for (int i = 0; i < 3; i++) put(1'b0, 1'b0, 4'h0);
    chk(frames == f0, "R6 no frame from tx_er", frames - f0, 0);
    chk(hunt_zero == z0, "R6 idle bits stay one", hunt_zero - z0, 0);

    // Fiber: raw symbols, no scrambling, level quiet (R11)
    do_reset(1'b1);
    f0 = frames;
    put(1'b0, 1'b1, 4'h8); put(1'b0, 1'b1, 4'h1);
    for (int i = 0; i < 6; i++) put(1'b0, FIB_SYM[i][4], FIB_SYM[i][3:0]);
    put(1'b0, 1'b0, 4'hD); put(1'b0, 1'b0, 4'h7);
    for (int i = 0; i < 6; i++) put(1'b0, 1'b1, 4'hF);
    chk(frames == f0 + 1, "R11 fiber frame detected", frames - f0, 1);
    chk(rx_n == 6, "R11 fiber symbol count", rx_n, 6);
    for (int i = 0; i < 6 && i < rx_n; i++)
      chk(rx_sym[i] == FIB_SYM[i], "R11 raw symbol", rx_sym[i], FIB_SYM[i]);
    chk(fib_lvl_bad == 0, "R11 level held at zero", fib_lvl_bad, 0);

    chk(tick_bad == 0, "R1 tick spacing", tick_bad, 0);
    chk(nrzi_bad == 0, "R9 nrzi toggles with line bit", nrzi_bad, 0);
    chk(lvl_bad == 0, "R10 level sequence", lvl_bad, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule